// File: doc/BRIEF.md
# Dual-Slot Bundle Dispatcher

This block takes a 64-bit instruction bundle and sequences it onto two execution lanes, a memory lane and an integer lane. A two-bit format code inside the bundle says whether the bundle holds one long instruction or two 32-bit short instructions. Short pairs are issued together in one cycle or one after the other in either order. For every issue step the dispatcher raises the lane valids and presents the slot words. The units answer in the same cycle with a branch-taken flag and a target. In sequential order the first instruction can also ask for its partner to be dropped.

The dispatcher merges the answers into one completion result: a taken flag with its target, or a fault when two parallel instructions both branch. A sequential bundle uses two issue cycles unless its first instruction stops the second. A long or parallel bundle uses one. A bundle is accepted while `inReady` is high and its first issue step follows in the next cycle. `doneValid` marks the cycle that completes the bundle, and `inReady` returns in the cycle after it.

Top module: `bundle_dispatch`

## Requirements
- R1: After reset `inReady` is 1 and `longIssue`, `memIssue`, `intIssue` and `doneValid` are all 0.
- R2: A bundle is captured on a clock edge where `inReady` and `bundleValid` are both 1. Its first issue step is the next cycle. `inReady` stays 0 until the cycle after `doneValid`, and then it is 1.
- R3: The format code is {bundle[63], bundle[31]}, which are bits 0 and 32 when bits are counted from the MSB. During every issue step of a bundle, `memWord` shows the captured bundle[63:32] (the left slot) and `intWord` shows bundle[31:0] (the right slot).
- R4: Code 3 (long) issues in one cycle with only `longIssue` high. That cycle completes the bundle, and the result is `memTaken`/`memTarget`.
- R5: Code 0 (parallel) raises `memIssue` and `intIssue` in the same single cycle, and that cycle completes the bundle.
- R6: Parallel merge works as follows. If neither lane branches, the result is not taken with target 0. If exactly one lane branches, the result is taken with that lane's target. If both branch, `doneFault` is 1, `doneTaken` is 0 and the target is 0.
- R7: Code 1 (left then right) issues the left slot with `memIssue` alone, then the right slot with `intIssue` alone.
- R8: Code 2 (right then left) issues the right slot with `intIssue` alone, then the left slot with `memIssue` alone.
- R9: In a sequential bundle, if the first step's lane reports taken or `killSecond` is 1, the second step is not issued. The bundle completes in the first step with that lane's result: a kill without a branch completes as not taken.
- R10: A sequential bundle that reaches its second step completes there, with the response of the lane issued in that step.
- R11: `killSecond` has no effect on long or parallel bundles.
- R12: `bundleValid` and `bundleIn` are ignored while a bundle is in flight, and the slot words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bundleValid | input | 1 | Bundle offered |
| bundleIn | input | 64 | Bundle, left slot in upper half |
| inReady | output | 1 | Dispatcher idle, can accept a bundle |
| longIssue | output | 1 | Long instruction issued this cycle |
| memIssue | output | 1 | Memory lane issue this cycle |
| intIssue | output | 1 | Integer lane issue this cycle |
| memWord | output | 32 | Left slot word |
| intWord | output | 32 | Right slot word |
| memTaken | input | 1 | Memory lane (or long) branch taken |
| memTarget | input | 32 | Memory lane branch target |
| intTaken | input | 1 | Integer lane branch taken |
| intTarget | input | 32 | Integer lane branch target |
| killSecond | input | 1 | First sequential instruction drops the second |
| doneValid | output | 1 | Bundle completes this cycle |
| doneTaken | output | 1 | Merged branch taken |
| doneTarget | output | 32 | Merged branch target, 0 when not taken |
| doneFault | output | 1 | Both parallel slots branched |

## Verification
The checker enforces several rules on every cycle. An accepted bundle must issue in the next cycle, and `inReady` must return after each completion. A long issue never overlaps a short-lane issue. A fault is only reported on a parallel completion that is not taken, and issue never happens while the dispatcher is idle. The bench sweeps all four format codes against every combination of lane branch and kill responses. Only those scenarios show the issue order, which step completes, the merged target values, the slot word routing, and that offers made while busy are ignored.

// File: rtl/bundle_dispatch_pkg.sv
package bundle_dispatch_pkg;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmtCode_t;

  typedef struct packed {
    logic load;     // capture the offered bundle
    logic stepOne;  // first issue step active
    logic stepTwo;  // second issue step active
    logic finish;   // this step completes the bundle
  } dispStrobe_t;

endpackage

// File: rtl/bundle_dispatch_ctrl.sv
module bundle_dispatch_ctrl
  import bundle_dispatch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bundleValid,
  input  fmtCode_t    fmt,
  input  logic        firstStop,
  output logic        inReady,
  output dispStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO} state_t;

  state_t state, stateNext;
  logic   seqFmt;

  assign seqFmt  = (fmt == FMT_LR) || (fmt == FMT_RL);
  assign inReady = (state == ST_IDLE);

  always_comb begin
    strobe.load    = inReady && bundleValid;
    strobe.stepOne = (state == ST_ONE);
    strobe.stepTwo = (state == ST_TWO);
    strobe.finish  = (strobe.stepOne && (!seqFmt || firstStop)) || strobe.stepTwo;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (bundleValid) stateNext = ST_ONE;
      ST_ONE:  stateNext = strobe.finish ? ST_IDLE : ST_TWO;
      ST_TWO:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/bundle_dispatch_dp.sv
module bundle_dispatch_dp
  import bundle_dispatch_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dispStrobe_t           strobe,
  input  logic [2*SLOT_W-1:0]   bundleIn,
  input  logic                  memTaken,
  input  logic [ADDR_W-1:0]     memTarget,
  input  logic                  intTaken,
  input  logic [ADDR_W-1:0]     intTarget,
  input  logic                  killSecond,
  output fmtCode_t              fmt,
  output logic                  firstStop,
  output logic                  longIssue,
  output logic                  memIssue,
  output logic                  intIssue,
  output logic [SLOT_W-1:0]     memWord,
  output logic [SLOT_W-1:0]     intWord,
  output logic                  doneValid,
  output logic                  doneTaken,
  output logic [ADDR_W-1:0]     doneTarget,
  output logic                  doneFault
);

  localparam int BUNDLE_W = 2 * SLOT_W;

  logic [BUNDLE_W-1:0] bundleQ;
  logic                seqTaken;
  logic [ADDR_W-1:0]   seqTarget;

  always_ff @(posedge clk) begin
    if (!rstN)            bundleQ <= '0;
    else if (strobe.load) bundleQ <= bundleIn;
  end

  // format bits sit at the top of each slot
  assign fmt     = fmtCode_t'({bundleQ[BUNDLE_W-1], bundleQ[SLOT_W-1]});
  assign memWord = bundleQ[BUNDLE_W-1:SLOT_W];
  assign intWord = bundleQ[SLOT_W-1:0];

  assign longIssue = strobe.stepOne && (fmt == FMT_LONG);
  assign memIssue  = (strobe.stepOne && ((fmt == FMT_PAR) || (fmt == FMT_LR)))
                  || (strobe.stepTwo && (fmt == FMT_RL));
  assign intIssue  = (strobe.stepOne && ((fmt == FMT_PAR) || (fmt == FMT_RL)))
                  || (strobe.stepTwo && (fmt == FMT_LR));

  // in a sequential step exactly one lane is active
  assign seqTaken  = memIssue ? memTaken  : intTaken;
  assign seqTarget = memIssue ? memTarget : intTarget;
  assign firstStop = seqTaken || killSecond;

  always_comb begin
    doneValid  = strobe.finish;
    doneTaken  = 1'b0;
    doneTarget = '0;
    doneFault  = 1'b0;
    if (strobe.finish) begin
      case (fmt)
        FMT_LONG: begin
          doneTaken  = memTaken;
          doneTarget = memTaken ? memTarget : '0;
        end
        FMT_PAR: begin
          if (memTaken && intTaken) begin
            doneFault = 1'b1;
          end else if (memTaken) begin
            doneTaken  = 1'b1;
            doneTarget = memTarget;
          end else if (intTaken) begin
            doneTaken  = 1'b1;
            doneTarget = intTarget;
          end
        end
        default: begin
          doneTaken  = seqTaken;
          doneTarget = seqTaken ? seqTarget : '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
  import bundle_dispatch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bundleValid,
  input  logic [63:0] bundleIn,
  output logic        inReady,
  output logic        longIssue,
  output logic        memIssue,
  output logic        intIssue,
  output logic [31:0] memWord,
  output logic [31:0] intWord,
  input  logic        memTaken,
  input  logic [31:0] memTarget,
  input  logic        intTaken,
  input  logic [31:0] intTarget,
  input  logic        killSecond,
  output logic        doneValid,
  output logic        doneTaken,
  output logic [31:0] doneTarget,
  output logic        doneFault
);

  localparam int SLOT_W = 32;
  localparam int ADDR_W = 32;

  dispStrobe_t strobe;
  fmtCode_t    fmt;
  logic        firstStop;

  bundle_dispatch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bundleValid(bundleValid),
    .fmt        (fmt),
    .firstStop  (firstStop),
    .inReady    (inReady),
    .strobe     (strobe)
  );

  bundle_dispatch_dp #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bundleIn  (bundleIn),
    .memTaken  (memTaken),
    .memTarget (memTarget),
    .intTaken  (intTaken),
    .intTarget (intTarget),
    .killSecond(killSecond),
    .fmt       (fmt),
    .firstStop (firstStop),
    .longIssue (longIssue),
    .memIssue  (memIssue),
    .intIssue  (intIssue),
    .memWord   (memWord),
    .intWord   (intWord),
    .doneValid (doneValid),
    .doneTaken (doneTaken),
    .doneTarget(doneTarget),
    .doneFault (doneFault)
  );

endmodule

// File: rtl/bundle_dispatch_chk.sv
module bundle_dispatch_chk (
  input logic clk,
  input logic rstN,
  input logic bundleValid,
  input logic inReady,
  input logic longIssue,
  input logic memIssue,
  input logic intIssue,
  input logic doneValid,
  input logic doneTaken,
  input logic doneFault
);

  // R2: an accepted bundle issues in the following cycle
  a_r2_issue_follows: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && bundleValid) |=> (longIssue || memIssue || intIssue));

  // R2: the dispatcher is ready again after completion
  a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> inReady);

  // R4: a long issue never shares a cycle with short lanes
  a_r4_long_alone: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({longIssue, memIssue || intIssue}));

  // R6: a fault only on a parallel completion that is not taken
  a_r6_fault_shape: assert property (@(posedge clk) disable iff (!rstN)
    doneFault |-> (doneValid && !doneTaken && memIssue && intIssue));

  // R1: nothing issues while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !(longIssue || memIssue || intIssue || doneValid));

endmodule

bind bundle_dispatch bundle_dispatch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bundleValid(bundleValid),
  .inReady    (inReady),
  .longIssue  (longIssue),
  .memIssue   (memIssue),
  .intIssue   (intIssue),
  .doneValid  (doneValid),
  .doneTaken  (doneTaken),
  .doneFault  (doneFault)
);

// File: tb/sim_bundle_dispatch.sv
module sim_bundle_dispatch;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bundleValid = 1'b0;
  logic [63:0] bundleIn = '0;
  logic        inReady, longIssue, memIssue, intIssue;
  logic [31:0] memWord, intWord;
  logic        memTaken = 1'b0, intTaken = 1'b0, killSecond = 1'b0;
  logic [31:0] memTarget = '0, intTarget = '0;
  logic        doneValid, doneTaken, doneFault;
  logic [31:0] doneTarget;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_dispatch u0 (
    .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .bundleIn(bundleIn),
    .inReady(inReady), .longIssue(longIssue), .memIssue(memIssue), .intIssue(intIssue),
    .memWord(memWord), .intWord(intWord), .memTaken(memTaken), .memTarget(memTarget),
    .intTaken(intTaken), .intTarget(intTarget), .killSecond(killSecond),
    .doneValid(doneValid), .doneTaken(doneTaken), .doneTarget(doneTarget),
    .doneFault(doneFault)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one issue step: lanes {long,mem,int}, completion and result
  task automatic checkStep(input string req, input logic [2:0] lanes,
                           input logic done, input logic tk,
                           input logic [31:0] tgt, input logic flt,
                           input logic [31:0] lw, input logic [31:0] rw);
    check(req, "lanes", {61'd0, longIssue, memIssue, intIssue}, {61'd0, lanes});
    check(req, "doneValid", {63'd0, doneValid}, {63'd0, done});
    if (done) begin
      check(req, "doneTaken", {63'd0, doneTaken}, {63'd0, tk});
      check(req, "doneTarget", {32'd0, doneTarget}, {32'd0, tgt});
      check(req, "doneFault", {63'd0, doneFault}, {63'd0, flt});
    end
    check("R3", "slot words", {memWord, intWord}, {lw, rw}); // R12 also: unchanged while busy
  endtask

  task automatic runCase(input logic [1:0] code, input logic mt, input logic it,
                         input logic kl, input int idx);
    logic [31:0] lw, rw, mT, iT;
    logic        stop;
    lw = {code[1], 31'(idx * 32'h0137_5A1D + 5)};
    rw = {code[0], 31'(idx * 32'h02C4_9E33 + 9)};
    mT = 32'h1000_0000 + 32'(idx);
    iT = 32'h2000_0000 + 32'(idx);
    @(posedge clk); #1;
    check("R2", "ready before offer", {63'd0, inReady}, 64'd1);
    bundleIn = {lw, rw}; bundleValid = 1'b1;
    memTaken = mt; intTaken = it; killSecond = kl;
    memTarget = mT; intTarget = iT;
    @(posedge clk); #1;
    bundleIn = ~{lw, rw};   // R12: offered while busy, must be ignored
    check("R2", "busy after accept", {63'd0, inReady}, 64'd0);
    case (code)
      2'd3: begin // R4, R11
        checkStep("R4", 3'b100, 1'b1, mt, mt ? mT : 32'd0, 1'b0, lw, rw);
      end
      2'd0: begin // R5, R6, R11
        checkStep("R6", 3'b011, 1'b1, mt ^ it,
                  (mt && !it) ? mT : ((it && !mt) ? iT : 32'd0), mt && it, lw, rw);
      end
      2'd1: begin
        stop = mt || kl;
        checkStep(stop ? "R9" : "R7", 3'b010, stop, mt, mt ? mT : 32'd0, 1'b0, lw, rw);
        if (!stop) begin
          @(posedge clk); #1;
          checkStep("R10", 3'b001, 1'b1, it, it ? iT : 32'd0, 1'b0, lw, rw);
        end
      end
      default: begin
        stop = it || kl;
        checkStep(stop ? "R9" : "R8", 3'b001, stop, it, it ? iT : 32'd0, 1'b0, lw, rw);
        if (!stop) begin
          @(posedge clk); #1;
          checkStep("R10", 3'b010, 1'b1, mt, mt ? mT : 32'd0, 1'b0, lw, rw);
        end
      end
    endcase
    bundleValid = 1'b0;
    @(posedge clk); #1;
    check("R2", "ready after done", {63'd0, inReady}, 64'd1);
    check("R12", "busy offer not taken", {61'd0, longIssue, memIssue, intIssue}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    check("R1", "ready at reset", {63'd0, inReady}, 64'd1);
    check("R1", "quiet at reset",
          {60'd0, longIssue, memIssue, intIssue, doneValid}, 64'd0);
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < 2; i++)
          for (int k = 0; k < 2; k++)
            runCase(2'(c), 1'(m), 1'(i), 1'(k), c * 8 + m * 4 + i * 2 + k);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule